// File: doc/BRIEF.md
# Jet Cluster Threshold Unit with Saturation Tracking

This block takes a square patch of 4x4 energy readings, each 10 bits wide, on every cycle that `in_valid` is high. First, a noise cut is applied to every reading. One programmable cut level is shared by all channels. A reading is kept only when it is strictly above the cut, and is otherwise replaced by zero. A reading at full scale (1023) skips the cut.

The kept readings are then added into one cluster total. Any total above 1023 is clamped to 1023. The clamped total is compared against eight programmable jet levels, which gives one hit bit per level.

The result is a registered region-of-interest word. It holds the eight hit bits and a saturation bit. The saturation bit reports that at least one reading in the patch sat at full scale. It does not depend on the size of the total. The result appears two cycles after its input, with a matching valid strobe. All levels are loaded through a small write port.

Top module: `jet_cluster_thresh`

## Requirements
- R1: A reading below full scale is kept only when it is strictly greater than the noise cut; a reading equal to or below the cut adds zero to the total.
- R2: The noise cut is one value applied identically to all sixteen channels, whatever the position of the reading in the patch.
- R3: `roi_valid_o` is high exactly two clock cycles after `in_valid` was sampled high and is low otherwise; `roi_o` holds its value while no new result arrives.
- R4: The cluster total is the sum of all sixteen kept readings; reading k occupies bits [10k+9:10k] of `in_elems`.
- R5: Hit bit i (`roi_o[i]`, i = 0..7) is set only when the clamped total is strictly greater than jet level i.
- R6: A reading of 1023 bypasses the noise cut: it always contributes 1023 and sets the saturation bit `roi_o[8]`, even when the cut is 1023.
- R7: The saturation bit stays clear when no reading is 1023, even when the total is clamped.
- R8: When the true total exceeds 1023, every hit bit is set, including those for levels of 1023.
- R9: A write with `cfg_we` high loads jet level i for `cfg_addr` = i (0..7) and loads the noise cut for `cfg_addr` = 8. Writes to addresses 9..15 change nothing.
- R10: While reset is high and after it is released, `roi_o` is zero and `roi_valid_o` is low, and all levels read as zero until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Patch present on `in_elems` |
| in_elems | input | 160 | Sixteen 10-bit readings, reading k at bits [10k+9:10k] |
| cfg_we | input | 1 | Level write enable |
| cfg_addr | input | 4 | 0..7 jet level, 8 noise cut |
| cfg_data | input | 10 | Level value |
| roi_o | output | 9 | Bit 8 saturation, bits 7:0 hit bits |
| roi_valid_o | output | 1 | Result valid strobe |

## Verification
Readings are placed one count either side of the noise cut and at the cut itself, which shows whether the comparison is strict. They are also swept across every channel position, which exposes any per-channel difference. Jet levels are set equal to the exact total and one count below it, so that strict and non-strict hit compares give different results. Patches of near-full readings without a 1023 separate clamping from saturation. A single 1023 reading under a cut of 1023 tests the bypass, and random streams with gaps test the latency and hold behaviour.

// File: rtl/jet_cluster_thresh.sv
module jet_cluster_thresh #(
  parameter int SIDE = 4,
  parameter int W    = 10,
  parameter int NTHR = 8,
  parameter int AW   = $clog2(NTHR + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [SIDE*SIDE*W-1:0] in_elems,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [W-1:0]         cfg_data,
  output logic [NTHR:0]        roi_o,
  output logic                 roi_valid_o
);
  localparam int NE = SIDE * SIDE;
  localparam int SW = W + $clog2(NE) + 1;
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] noise_thr;
  logic [W-1:0] jet_thr [NTHR];
  logic [W-1:0] filt [NE];
  logic [NE-1:0] sat1;
  logic          v1;
  logic [SW-1:0] total;
  logic          over;
  logic [W-1:0]  csum;
  logic [NTHR-1:0] hit;
  logic          in_has_sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      noise_thr <= '0;
      for (int i = 0; i < NTHR; i++) jet_thr[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NTHR; i++)
        if (cfg_addr == AW'(i)) jet_thr[i] <= cfg_data;
      if (cfg_addr == AW'(NTHR)) noise_thr <= cfg_data;
    end
  end

  for (genvar g = 0; g < NE; g++) begin : g_cut
    wire [W-1:0] raw = in_elems[g*W +: W];
    wire         is_sat = (raw == FULL);
    always_ff @(posedge clk) begin
      if (rst) begin
        filt[g] <= '0;
        sat1[g] <= 1'b0;
      end else if (in_valid) begin
        filt[g] <= is_sat ? FULL : ((raw > noise_thr) ? raw : '0);
        sat1[g] <= is_sat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < NE; i++) total = total + SW'(filt[i]);
  end

  assign over = (total > SW'(FULL));
  assign csum = over ? FULL : total[W-1:0];

  always_comb
    for (int i = 0; i < NTHR; i++) hit[i] = over | (csum > jet_thr[i]);

  always_ff @(posedge clk) begin
    if (rst) begin
      roi_o       <= '0;
      roi_valid_o <= 1'b0;
    end else begin
      roi_valid_o <= v1;
      if (v1) roi_o <= {|sat1, hit};
    end
  end

  always_comb begin
    in_has_sat = 1'b0;
    for (int i = 0; i < NE; i++)
      if (in_elems[i*W +: W] == FULL) in_has_sat = 1'b1;
  end

  p_stage1_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> v1);
  p_stage2_r3: assert property (@(posedge clk) disable iff (rst)
    v1 |=> roi_valid_o);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> $stable(roi_o));
  p_clamp_all_r8: assert property (@(posedge clk) disable iff (rst)
    (v1 && over) |=> (&roi_o[NTHR-1:0]));
  p_sat_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_has_sat) |-> ##2 roi_o[NTHR]);
  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (roi_o == '0 && !roi_valid_o));
endmodule

// File: tb/test_jet_cluster_thresh.sv
module test_jet_cluster_thresh;
  localparam int NE = 16;
  localparam int W  = 10;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [NE*W-1:0] in_elems = '0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [W-1:0] cfg_data = '0;
  logic [8:0] roi_o;
  logic roi_valid_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R10";
  bit live = 0;

  int m_noise = 0;
  int m_jet [8];

  bit        sh_v1 = 0, sh_v2 = 0;
  logic [8:0] e1 = '0, e2 = '0;

  always #2.5 clk = ~clk;

  jet_cluster_thresh i_jet_cluster_thresh (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_elems(in_elems),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .roi_o(roi_o), .roi_valid_o(roi_valid_o));

  function automatic logic [8:0] model(logic [NE*W-1:0] v);
    int tot = 0;
    bit s = 0;
    logic [8:0] r;
    for (int k = 0; k < NE; k++) begin
      int x = int'(v[k*W +: W]);
      if (x == 1023) begin s = 1; tot += 1023; end
      else if (x > m_noise) tot += x;
    end
    for (int i = 0; i < 8; i++) r[i] = (tot > 1023) || (tot > m_jet[i]);
    r[8] = s;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      sh_v1 <= 0; sh_v2 <= 0; e1 <= '0; e2 <= '0;
      m_noise <= 0;
      for (int i = 0; i < 8; i++) m_jet[i] <= 0;
    end else begin
      sh_v1 <= in_valid;
      if (in_valid) e1 <= model(in_elems);
      sh_v2 <= sh_v1;
      if (sh_v1) e2 <= e1;
      if (cfg_we) begin
        if (cfg_addr < 8) m_jet[cfg_addr] <= int'(cfg_data);
        else if (cfg_addr == 8) m_noise <= int'(cfg_data);
      end
    end
  end

  always @(negedge clk) if (live) begin
    checks++;
    if (roi_valid_o !== sh_v2 || roi_o !== e2) begin
      failures++;
      $display("FAIL %s: roi_valid=%b roi=%h expected roi_valid=%b roi=%h",
               cur_req, roi_valid_o, roi_o, sh_v2, e2);
    end
  end

  task automatic send(logic [NE*W-1:0] v);
    @(negedge clk);
    in_valid = 1; in_elems = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    in_valid = 0; cfg_we = 1; cfg_addr = 4'(a); cfg_data = 10'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [NE*W-1:0] fill(int val);
    logic [NE*W-1:0] v;
    for (int k = 0; k < NE; k++) v[k*W +: W] = 10'(val);
    return v;
  endfunction

  initial begin
    logic [NE*W-1:0] v;
    repeat (3) @(negedge clk);
    checks++;
    if (roi_o !== '0 || roi_valid_o !== 1'b0) begin
      failures++;
      $display("FAIL R10: roi=%h valid=%b expected 0 0", roi_o, roi_valid_o);
    end
    @(negedge clk); rst = 0;
    live = 1;
    cur_req = "R10"; send(fill(1)); idle(3);

    cur_req = "R1"; wr(8, 100);
    v = '0; v[0 +: W] = 10'd100; v[W +: W] = 10'd101; v[2*W +: W] = 10'd99;
    send(v); send(fill(100)); send(fill(101)); idle(3);

    cur_req = "R2";
    for (int k = 0; k < NE; k++) begin
      v = '0; v[k*W +: W] = 10'd101; send(v);
      v[k*W +: W] = 10'd100; send(v);
    end
    idle(3);

    cur_req = "R4"; wr(8, 0);
    v = '0;
    for (int k = 0; k < NE; k++) v[k*W +: W] = 10'(k + 1);
    send(v); send(fill(63)); send(fill(64)); idle(3);

    cur_req = "R5";
    for (int i = 0; i < 8; i++) wr(i, 130 + i - 4);
    send(v); send(fill(8)); idle(3);

    cur_req = "R6"; wr(8, 1023);
    v = '0; v[5*W +: W] = 10'd1023; send(v);
    v = fill(1022); send(v); idle(3);
    wr(8, 0);

    cur_req = "R7"; send(fill(1022)); send(fill(500)); idle(3);

    cur_req = "R8";
    for (int i = 0; i < 8; i++) wr(i, 1023);
    v = '0; v[0 +: W] = 10'd1000; v[W +: W] = 10'd24; send(v);
    v[W +: W] = 10'd23; send(v); idle(3);

    cur_req = "R9";
    for (int a = 9; a < 16; a++) wr(a, 5);
    v = '0; v[0 +: W] = 10'd3; send(v); send(fill(20)); idle(3);

    cur_req = "R3"; wr(8, 40);
    for (int i = 0; i < 8; i++) wr(i, i * 120);
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < NE; k++) v[k*W +: W] = 10'($urandom_range(0, 1023) >> $urandom_range(0, 4));
      if ($urandom_range(0, 3) == 0) idle(1 + $urandom_range(0, 2));
      else send(v);
    end
    idle(4);
    live = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule